// File: doc/BRIEF.md
# Strap Capture and Shared Clock Pin Router

This block owns the pads that do double duty on a clock generator. While power-on reset is held, each strap pad is an input carrying a board-level pull-up or pull-down. A short sequencer counts reference-clock cycles after the raw power-on reset is released. At a fixed lead ahead of the end of that window, it captures every strap pad into a latch. One cycle later it turns the pads around into outputs. At the end of the window it releases the system reset to the rest of the chip.

The captured bits become power-up defaults for the register file: a 4-bit frequency code and the 24/48 MHz select. Two mode bits decide what three shared pads carry. Each shared pad carries either a HyperTransport clock or a PCI clock. The block drives a per-pad source select and the gated pad data for the three shared pads and the 24/48 MHz pad. Every output is forced low while its enable bit is clear, and also while the pads are still inputs.

Top module: `clkpin_strap_top`

## Requirements
- R1: `rst_out_n` is 0 while `rst_n` is 0 and for the first POR_CYCLES-1 clock edges after `rst_n` rises. It is 1 from edge POR_CYCLES onward.
- R2: The value on `pad_in` is captured at edge POR_CYCLES-SAMPLE_LEAD+1 after reset release. Values that are present only before that edge are not captured.
- R3: After capture, changes on `pad_in` have no effect on `fs_dflt`, `sel24_dflt` or `sel_ht` until `rst_n` is next asserted. A new power-on cycle captures the new value.
- R4: `pad_oe` is all zero until the edge after capture, and all ones from that edge onward. The pads never drive in the cycle in which they are sampled.
- R5: `fs_dflt[i]` equals the captured `pad_in[i]` for i = 0..3.
- R6: `sel24_dflt` equals the captured `pad_in[4]`. `out_2448` carries `clk24` when `reg_sel24` is 1 and `clk48` when it is 0.
- R7: The mode is A = captured `pad_in[5]` and B = captured `pad_in[6]`. `sel_ht` bit 0 belongs to shared pad 0 (HT1 or PCI8), bit 1 to pad 1 (HT2 or PCI9) and bit 2 to pad 2 (HT3 or PCI11); a 1 selects HT. Mode AB=00 gives 011, 01 gives 111, 10 gives 000 and 11 gives 001.
- R8: `shared_out[i]` equals `ht_clk[i]` when `sel_ht[i]` is 1 and `pci_clk[i]` when it is 0. This holds while the pads drive and `out_en[i]` is 1.
- R9: The following outputs are held at 0 whenever the matching enable bit is 0 or `pad_oe` is 0: `shared_out[i]` (enable bit `out_en[i]`) and `out_2448` (enable bit `out_en[3]`).
- R10: While `rst_n` is 0, all of the following are 0: `pad_oe`, `rst_out_n`, `fs_dflt`, `sel24_dflt`, `shared_out` and `out_2448`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Raw power-on reset, active low, asynchronous |
| pad_in | input | 7 | Strap pad levels: FS[3:0], 24/48 select, mode A, mode B |
| pad_oe | output | 7 | Pad output enables, 1 = pad drives |
| rst_out_n | output | 1 | System reset released at the end of the power-on window |
| fs_dflt | output | 4 | Captured frequency code, reset value for the register file |
| sel24_dflt | output | 1 | Captured 24/48 select, reset value for the register file |
| ht_clk | input | 3 | HyperTransport clock sources HT1..HT3 |
| pci_clk | input | 3 | PCI clock sources PCI8, PCI9, PCI11 |
| out_en | input | 4 | Enables: bits 2:0 shared pads, bit 3 the 24/48 pad |
| reg_sel24 | input | 1 | Live 24/48 select from the register file |
| clk24 | input | 1 | 24 MHz source |
| clk48 | input | 1 | 48 MHz source |
| sel_ht | output | 3 | Per-shared-pad source select, 1 = HT |
| shared_out | output | 3 | Gated data for the three shared pads |
| out_2448 | output | 1 | Gated data for the 24/48 MHz pad |

## Verification
The bench presents the strap value on the pads only in the single cycle before the capture edge, with junk on either side. A sampler that fires one edge early or late therefore latches junk and reports the wrong frequency code or mode. It checks that `pad_oe` is still low in the capture cycle and high one cycle later. A turn-around without that gap would drive against the straps, and a missing turn-around would leave the pads dead. All four mode codes are forced, then random ones are drawn. A swapped A/B or a wrong table row misroutes a shared pad between its HT and PCI source. Pad wiggling after capture and random enable patterns expose a latch that is not frozen and a disabled pad that leaks its clock.

// File: rtl/clkpin_pkg.sv
package clkpin_pkg;

    // Captured strap image; bit positions match pad_in.
    typedef struct packed {
        logic       mode_b;
        logic       mode_a;
        logic       sel24;
        logic [3:0] fs;
    } strap_t;

    localparam int STRAP_W  = $bits(strap_t);
    localparam int SHARED_N = 3;

    // Per-pad HT select for a mode pair; bit i belongs to shared pad i.
    function automatic logic [SHARED_N-1:0] ht_route(input logic a, input logic b);
        logic [SHARED_N-1:0] r;
        case ({a, b})
            2'b00:   r = 3'b011;
            2'b01:   r = 3'b111;
            2'b10:   r = 3'b000;
            default: r = 3'b001;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/clkpin_por_seq.sv
module clkpin_por_seq #(
    parameter int POR_CYCLES  = 16,
    parameter int SAMPLE_LEAD = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic vld_i,
    output logic sample_o,
    output logic oe_o,
    output logic release_o
);
    localparam int CW        = $clog2(POR_CYCLES + 1);
    localparam int SAMPLE_AT = POR_CYCLES - SAMPLE_LEAD;
    localparam logic [CW-1:0] LAST_C = CW'(POR_CYCLES);
    localparam logic [CW-1:0] AT_C   = CW'(SAMPLE_AT);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          oe;
    } seq_t;

    seq_t q, d;

    always_comb begin
        d = q;
        if (q.cnt != LAST_C) begin
            d.cnt = q.cnt + 1'b1;
        end
        // turn-around trails the latch by one cycle
        d.oe = vld_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign sample_o  = (q.cnt == AT_C);
    assign oe_o      = q.oe;
    assign release_o = (q.cnt == LAST_C);

    // R1
    release_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        release_o |=> release_o);

    // R2
    sample_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sample_o |=> !sample_o);

endmodule

// File: rtl/clkpin_strap_latch.sv
module clkpin_strap_latch
    import clkpin_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sample_i,
    input  logic [STRAP_W-1:0] pad_i,
    output strap_t             strap_o,
    output logic               vld_o
);
    typedef struct packed {
        strap_t strap;
        logic   vld;
    } lat_t;

    lat_t q, d;

    always_comb begin
        d = q;
        if (sample_i && !q.vld) begin
            d.strap = strap_t'(pad_i);
            d.vld   = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign strap_o = q.strap;
    assign vld_o   = q.vld;

    // R2
    capture_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sample_i |=> (strap_o == $past(pad_i)));

    // R3
    strap_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vld_o |=> $stable(strap_o));

endmodule

// File: rtl/clkpin_pin_mux.sv
module clkpin_pin_mux
    import clkpin_pkg::*;
(
    input  logic                oe_i,
    input  logic                mode_a_i,
    input  logic                mode_b_i,
    input  logic [SHARED_N-1:0] ht_clk_i,
    input  logic [SHARED_N-1:0] pci_clk_i,
    input  logic [SHARED_N:0]   en_i,
    input  logic                sel24_i,
    input  logic                clk24_i,
    input  logic                clk48_i,
    output logic [SHARED_N-1:0] sel_ht_o,
    output logic [SHARED_N-1:0] shared_o,
    output logic                out2448_o
);
    always_comb begin
        sel_ht_o = ht_route(mode_a_i, mode_b_i);
    end

    for (genvar i = 0; i < SHARED_N; i++) begin : g_pad
        logic src;
        always_comb begin
            src         = sel_ht_o[i] ? ht_clk_i[i] : pci_clk_i[i];
            shared_o[i] = src & en_i[i] & oe_i;
        end
    end

    always_comb begin
        out2448_o = (sel24_i ? clk24_i : clk48_i) & en_i[SHARED_N] & oe_i;
    end

endmodule

// File: rtl/clkpin_strap_top.sv
module clkpin_strap_top
    import clkpin_pkg::*;
#(
    parameter int POR_CYCLES  = 16,
    parameter int SAMPLE_LEAD = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [STRAP_W-1:0]  pad_in,
    output logic [STRAP_W-1:0]  pad_oe,
    output logic                rst_out_n,
    output logic [3:0]          fs_dflt,
    output logic                sel24_dflt,
    input  logic [SHARED_N-1:0] ht_clk,
    input  logic [SHARED_N-1:0] pci_clk,
    input  logic [SHARED_N:0]   out_en,
    input  logic                reg_sel24,
    input  logic                clk24,
    input  logic                clk48,
    output logic [SHARED_N-1:0] sel_ht,
    output logic [SHARED_N-1:0] shared_out,
    output logic                out_2448
);
    if (SAMPLE_LEAD < 2 || SAMPLE_LEAD >= POR_CYCLES) begin : g_bad_cfg
        $error("SAMPLE_LEAD must lie in [2, POR_CYCLES-1]");
    end

    logic   sample, vld, oe, released;
    strap_t strap;

    clkpin_por_seq #(
        .POR_CYCLES  (POR_CYCLES),
        .SAMPLE_LEAD (SAMPLE_LEAD)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .vld_i     (vld),
        .sample_o  (sample),
        .oe_o      (oe),
        .release_o (released)
    );

    clkpin_strap_latch u_lat (
        .clk      (clk),
        .rst_n    (rst_n),
        .sample_i (sample),
        .pad_i    (pad_in),
        .strap_o  (strap),
        .vld_o    (vld)
    );

    clkpin_pin_mux u_mux (
        .oe_i      (oe),
        .mode_a_i  (strap.mode_a),
        .mode_b_i  (strap.mode_b),
        .ht_clk_i  (ht_clk),
        .pci_clk_i (pci_clk),
        .en_i      (out_en),
        .sel24_i   (reg_sel24),
        .clk24_i   (clk24),
        .clk48_i   (clk48),
        .sel_ht_o  (sel_ht),
        .shared_o  (shared_out),
        .out2448_o (out_2448)
    );

    assign pad_oe     = {STRAP_W{oe}};
    assign rst_out_n  = released;
    assign fs_dflt    = strap.fs;
    assign sel24_dflt = strap.sel24;

    // R4
    oe_after_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oe) |-> $past(vld));

    // R4
    no_drive_while_sampling_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sample |-> !oe);

    // R1
    release_after_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_out_n |-> (pad_oe == {STRAP_W{1'b1}}));

    // R9
    quiet_until_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !oe |-> (shared_out == '0 && !out_2448));

    // R7
    route_nesting_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_ht[2] |-> sel_ht[1]) and (sel_ht[1] |-> sel_ht[0]));

endmodule

// File: tb/sim_clkpin_strap_top.sv
`timescale 1ns/1ps
module sim_clkpin_strap_top;
    localparam int POR   = 16;
    localparam int LEAD  = 4;
    localparam int AT    = POR - LEAD;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] pad_in = '0;
    logic [6:0] pad_oe;
    logic       rst_out_n;
    logic [3:0] fs_dflt;
    logic       sel24_dflt;
    logic [2:0] ht_clk = '0, pci_clk = '0, sel_ht, shared_out;
    logic [3:0] out_en = '1;
    logic       reg_sel24 = 1'b0, clk24 = 1'b0, clk48 = 1'b0, out_2448;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    clkpin_strap_top #(.POR_CYCLES(POR), .SAMPLE_LEAD(LEAD)) u0 (
        .clk(clk), .rst_n(rst_n), .pad_in(pad_in), .pad_oe(pad_oe),
        .rst_out_n(rst_out_n), .fs_dflt(fs_dflt), .sel24_dflt(sel24_dflt),
        .ht_clk(ht_clk), .pci_clk(pci_clk), .out_en(out_en),
        .reg_sel24(reg_sel24), .clk24(clk24), .clk48(clk48),
        .sel_ht(sel_ht), .shared_out(shared_out), .out_2448(out_2448)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Expected HT selects from the mode table (pad0, pad1, pad2).
    function automatic logic [2:0] exp_route(input logic a, input logic b);
        logic p0, p1, p2;
        p0 = !(a && !b);
        p1 = !a;
        p2 = !a && b;
        return {p2, p1, p0};
    endfunction

    task automatic mux_round(input logic [6:0] s, input logic drv);
        logic [2:0] r;
        logic [2:0] e;
        logic       e24;
        @(negedge clk);
        ht_clk    = 3'($urandom);
        pci_clk   = 3'($urandom);
        out_en    = 4'($urandom);
        reg_sel24 = 1'($urandom);
        clk24     = 1'($urandom);
        clk48     = 1'($urandom);
        #1;
        r = exp_route(s[5], s[6]);
        for (int i = 0; i < 3; i++) begin
            e[i] = drv & out_en[i] & (r[i] ? ht_clk[i] : pci_clk[i]);
        end
        e24 = drv & out_en[3] & (reg_sel24 ? clk24 : clk48);
        // R8 R9
        chk(shared_out == e, "R8/R9 shared pads", shared_out, e);
        // R6 R9
        chk(out_2448 == e24, "R6/R9 24/48 pad", out_2448, e24);
    endtask

    task automatic power_cycle(input logic [6:0] s);
        logic [6:0] junk;
        @(negedge clk);
        rst_n  = 1'b0;
        pad_in = ~s;
        out_en = '1;
        ht_clk = '1; pci_clk = '1; clk24 = 1'b1; clk48 = 1'b1;
        @(negedge clk);
        // R10
        chk(pad_oe == 0 && !rst_out_n && fs_dflt == 0 && !sel24_dflt
            && shared_out == 0 && !out_2448, "R10 reset state",
            {pad_oe, rst_out_n, fs_dflt, sel24_dflt, shared_out, out_2448}, 0);
        rst_n = 1'b1;
        for (int k = 1; k <= POR; k++) begin
            @(posedge clk);
            @(negedge clk);
            if (k == AT) begin
                // R4 not yet driving
                chk(pad_oe == 0, "R4 oe before capture", pad_oe, 0);
                pad_in = s;
            end
            if (k == AT + 1) begin
                // R2 R5 R6 R7
                chk(fs_dflt == s[3:0], "R2/R5 fs captured", fs_dflt, s[3:0]);
                chk(sel24_dflt == s[4], "R6 sel24 captured", sel24_dflt, s[4]);
                chk(sel_ht == exp_route(s[5], s[6]), "R7 mode route",
                    sel_ht, exp_route(s[5], s[6]));
                // R4 gap cycle
                chk(pad_oe == 0, "R4 oe in capture cycle", pad_oe, 0);
                // R9 quiet before drive
                chk(shared_out == 0 && !out_2448, "R9 quiet before drive",
                    {shared_out, out_2448}, 0);
                junk   = 7'($urandom);
                pad_in = junk;
            end
            if (k == AT + 2) begin
                // R4
                chk(pad_oe == 7'h7f, "R4 oe one cycle later", pad_oe, 7'h7f);
            end
            if (k == POR - 1) begin
                // R1
                chk(!rst_out_n, "R1 still in reset", rst_out_n, 0);
            end
        end
        // R1
        chk(rst_out_n, "R1 released", rst_out_n, 1);
        for (int n = 0; n < 6; n++) begin
            mux_round(s, 1'b1);
            pad_in = 7'($urandom);
        end
        @(negedge clk);
        // R3
        chk({sel_ht, sel24_dflt, fs_dflt} == {exp_route(s[5], s[6]), s[4], s[3:0]},
            "R3 strap frozen", {sel_ht, sel24_dflt, fs_dflt},
            {exp_route(s[5], s[6]), s[4], s[3:0]});
    endtask

    initial begin
        void'($urandom(32'd20250));
        repeat (2) @(negedge clk);
        for (int m = 0; m < 4; m++) begin
            logic [6:0] s;
            s = {m[0], m[1], 1'($urandom), 4'($urandom)};
            power_cycle(s);
        end
        power_cycle(7'h00);
        power_cycle(7'h7f);
        for (int t = 0; t < 10; t++) begin
            power_cycle(7'($urandom));
        end
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule